// File: doc/BRIEF.md
# Host Register Lock and Configuration Strap Capture

This block is a byte-wide slice of a display controller's host register file. It holds a control register with a host-interface lock bit and a half-frame-buffer disable bit. It also holds two read-only registers that report sixteen configuration strap pins, captured when reset is released. The lock comes out of reset set. While it is set, the block qualifies every host access against a short whitelist and reports the result on `access_ok`. The rest of the register file and the memory path use that qualifier to block themselves. Software opens the full register space by clearing the lock.

The half-frame-buffer disable is split into two values. One is a requested value, which is what software reads back. The other is an applied value, which drives the `hfb_en` output. A new request waits until the vertical non-display flag is high and only then reaches the output, so the buffer never changes mode while a frame is being scanned out. In single-panel mode the buffer is always off, whatever the register holds.

The host bus is a plain synchronous strobe interface with no back-pressure. A write completes at the clock edge where `wr_en` is high. A read is sampled at the edge where `rd_en` is high, and its data appears on `rd_data` during the following cycle. In any cycle that follows a cycle without a read, `rd_data` is 0.

Top module: `cfg_lock_slice`

## Requirements
- R1: After reset the lock bit (bit 7 of address 1Bh) is 1 and the disable request (bit 0) is 0, so a read of 1Bh returns 80h and `hfb_en` equals `dual_panel`.
- R2: While the lock is 1, `access_ok` is high only for addresses 1Ah, 1Bh and 28h through 2Fh, and low for all others.
- R3: While the lock is 0, `access_ok` is high for every address.
- R4: A read at an address with `access_ok` low returns 00h, and a write there changes nothing.
- R5: Bits 6 to 1 of 1Bh always read as 0 and ignore writes. Bit 7 and bit 0 take the written value on every write to 1Bh, whether or not the block is locked.
- R6: At the first clock edge after `rst_n` rises, the block captures `strap_pins`. Address 1Ch then reads pins 7:0 and 1Dh reads pins 15:8. Later changes on the pins do not affect what these addresses read.
- R7: Writes to 1Ah, 1Ch and 1Dh have no effect. 1Ah reads 00h from this slice.
- R8: A write of bit 0 of 1Bh only requests a change. `hfb_en` follows the request at the first clock edge at which `vnd` is high. If that edge is also the write's edge, the newly written value is applied.
- R9: When `dual_panel` is 0, `hfb_en` is 0. When `dual_panel` is 1, `hfb_en` is the inverse of the applied disable bit.
- R10: `rd_data` is registered. It shows the data for a read one cycle after `rd_en`, and it is 00h in any cycle not preceded by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; strap capture follows its release |
| addr | input | 6 | Host register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| strap_pins | input | 16 | Configuration strap pins |
| dual_panel | input | 1 | 1 selects dual-panel mode, 0 single-panel mode |
| vnd | input | 1 | Vertical non-display flag; 1 means the half frame buffer is idle |
| access_ok | output | 1 | The access at `addr` is permitted in this cycle |
| hfb_en | output | 1 | Effective half-frame-buffer enable |

## Verification
Two functions can meet at one clock edge: a write of the disable bit and the idle window that applies pending requests. The bench provokes this by raising `vnd` in the same cycle as a write to 1Bh. It expects `hfb_en` to reflect the freshly written bit right after that edge, not the older request. In a second case, a write is made outside the window. The bench then checks that `hfb_en` keeps its old value while the readback already shows the new request, and that the change lands on the next cycle with `vnd` high.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int STRAP_W = 16;

  localparam logic [ADDR_W-1:0] A_STATUS  = 6'h1A;
  localparam logic [ADDR_W-1:0] A_MISC    = 6'h1B;
  localparam logic [ADDR_W-1:0] A_STRAPLO = 6'h1C;
  localparam logic [ADDR_W-1:0] A_STRAPHI = 6'h1D;
  localparam logic [ADDR_W-1:0] A_WIN_LO  = 6'h28;
  localparam logic [ADDR_W-1:0] A_WIN_HI  = 6'h2F;

  localparam int LOCK_BIT = 7;
  localparam int HFB_BIT  = 0;
endpackage

// File: rtl/cls_access_gate.sv
module cls_access_gate
  import cls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              lock_wbit,
  input  logic              hfb_wbit,
  output logic              lock,
  output logic              hfb_req,
  output logic              misc_wr,
  output logic              access_ok
);
  logic on_list;

  always_comb begin
    on_list = (addr == A_STATUS) || (addr == A_MISC) ||
              ((addr >= A_WIN_LO) && (addr <= A_WIN_HI));
    access_ok = !lock || on_list;
    misc_wr   = wr_en && (addr == A_MISC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b1;
      hfb_req <= 1'b0;
    end else if (misc_wr) begin
      lock    <= lock_wbit;
      hfb_req <= hfb_wbit;
    end
  end

  // R1
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_MISC) |=> $stable(lock));

  // R2
  locked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && addr == A_STRAPLO) |-> !access_ok);
endmodule

// File: rtl/cls_strap_capture.sv
module cls_strap_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] straps
);
  logic cap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done <= 1'b0;
      straps   <= '0;
    end else if (!cap_done) begin
      cap_done <= 1'b1;
      straps   <= pins;
    end
  end

  // R6
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> $stable(straps));
endmodule

// File: rtl/cls_hfb_ctrl.sv
module cls_hfb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic vnd,
  input  logic dual_panel,
  input  logic misc_wr,
  input  logic wr_bit,
  input  logic hfb_req,
  output logic hfb_en
);
  logic dis_applied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dis_applied <= 1'b0;
    else if (vnd) dis_applied <= misc_wr ? wr_bit : hfb_req;
  end

  assign hfb_en = dual_panel && !dis_applied;

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vnd |=> $stable(dis_applied));
endmodule

// File: rtl/cfg_lock_slice.sv
module cfg_lock_slice
  import cls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               dual_panel,
  input  logic               vnd,
  output logic               access_ok,
  output logic               hfb_en
);
  localparam int HALF = STRAP_W / 2;

  logic               lock, hfb_req, misc_wr;
  logic [STRAP_W-1:0] straps;
  logic [DATA_W-1:0]  rd_mux;

  cls_access_gate u_gate (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .lock_wbit(wr_data[LOCK_BIT]), .hfb_wbit(wr_data[HFB_BIT]),
    .lock(lock), .hfb_req(hfb_req), .misc_wr(misc_wr), .access_ok(access_ok)
  );

  cls_strap_capture #(.W(STRAP_W)) u_strap (
    .clk(clk), .rst_n(rst_n), .pins(strap_pins), .straps(straps)
  );

  cls_hfb_ctrl u_hfb (
    .clk(clk), .rst_n(rst_n), .vnd(vnd), .dual_panel(dual_panel),
    .misc_wr(misc_wr), .wr_bit(wr_data[HFB_BIT]), .hfb_req(hfb_req),
    .hfb_en(hfb_en)
  );

  always_comb begin
    rd_mux = '0;
    if (access_ok) begin
      unique case (addr)
        A_MISC: begin
          rd_mux[LOCK_BIT] = lock;
          rd_mux[HFB_BIT]  = hfb_req;
        end
        A_STRAPLO: rd_mux = straps[HALF-1:0];
        A_STRAPHI: rd_mux = straps[STRAP_W-1:HALF];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  // R4
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !access_ok) |=> (rd_data == '0));

  // R5
  misc_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MISC) |=> (rd_data[LOCK_BIT-1:HFB_BIT+1] == '0));

  // R9
  single_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_panel |-> !hfb_en);

  // R10
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
endmodule

// File: tb/cfg_lock_slice_tb.sv
module cfg_lock_slice_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 read, 2 access check
    logic [5:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 6'h1B, 8'h00, 8'h80, 4'd1},  // R1 reset readback
    '{2'd2, 6'h1C, 8'h00, 8'h00, 4'd2},  // R2 locked, off list
    '{2'd2, 6'h2A, 8'h00, 8'h01, 4'd2},  // R2 window
    '{2'd2, 6'h1A, 8'h00, 8'h01, 4'd2},  // R2 status address
    '{2'd2, 6'h30, 8'h00, 8'h00, 4'd2},  // R2 just past window
    '{2'd1, 6'h1C, 8'h00, 8'h00, 4'd4},  // R4 blocked read
    '{2'd0, 6'h1B, 8'h7E, 8'h00, 4'd5},  // unlock, pad bits written 1
    '{2'd1, 6'h1B, 8'h00, 8'h00, 4'd5},  // R5 pad reads 0
    '{2'd2, 6'h05, 8'h00, 8'h01, 4'd3},  // R3 unlocked
    '{2'd1, 6'h1C, 8'h00, 8'h3C, 4'd6},  // R6 low straps
    '{2'd1, 6'h1D, 8'h00, 8'hA5, 4'd6},  // R6 high straps
    '{2'd0, 6'h1C, 8'hFF, 8'h00, 4'd7},
    '{2'd1, 6'h1C, 8'h00, 8'h3C, 4'd7},  // R7 strap write ignored
    '{2'd0, 6'h1A, 8'hFF, 8'h00, 4'd7},
    '{2'd1, 6'h1A, 8'h00, 8'h00, 4'd7}   // R7 status reads 0
  };

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, dual_panel = 1, vnd = 0;
  logic [5:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [15:0] strap_pins = 16'hA53C;
  logic access_ok, hfb_en;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lock_slice u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .strap_pins(strap_pins),
    .dual_panel(dual_panel), .vnd(vnd), .access_ok(access_ok), .hfb_en(hfb_en)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); strap_pins = 16'hFFFF;
    check("R1 hfb_en after reset", {7'd0, hfb_en}, 8'h01);
    check("R10 idle rd_data", rd_data, 8'h00);
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: begin
          rd(VECS[i].addr, v);
          check($sformatf("R%0d read %02h", VECS[i].req, VECS[i].addr), v, VECS[i].exp);
        end
        default: begin
          @(negedge clk); addr = VECS[i].addr; #1;
          check($sformatf("R%0d access %02h", VECS[i].req, VECS[i].addr),
                {7'd0, access_ok}, VECS[i].exp);
        end
      endcase
    end
    // R8 request pends outside idle window
    wr(6'h1B, 8'h01);
    check("R8 hfb_en held", {7'd0, hfb_en}, 8'h01);
    rd(6'h1B, v);
    check("R8 request readback", v, 8'h01);
    @(negedge clk); vnd = 1;
    @(negedge clk); vnd = 0;
    check("R8 applied in window", {7'd0, hfb_en}, 8'h00);
    // R8 write and window in same cycle
    @(negedge clk); addr = 6'h1B; wr_data = 8'h00; wr_en = 1; vnd = 1;
    @(negedge clk); wr_en = 0; vnd = 0;
    check("R8 coincident write", {7'd0, hfb_en}, 8'h01);
    // R9 single panel
    wr(6'h1B, 8'h01);
    @(negedge clk); vnd = 1;
    @(negedge clk); vnd = 0; dual_panel = 0; #1;
    check("R9 single panel off", {7'd0, hfb_en}, 8'h00);
    wr(6'h1B, 8'h00);
    @(negedge clk); vnd = 1;
    @(negedge clk); vnd = 0; #1;
    check("R9 single panel stays off", {7'd0, hfb_en}, 8'h00);
    dual_panel = 1; #1;
    check("R9 dual panel on", {7'd0, hfb_en}, 8'h01);
    // R5 relock via write, bits 7 and 0 taken
    wr(6'h1B, 8'hFF);
    rd(6'h1B, v);
    check("R5 relock readback", v, 8'h81);
    @(negedge clk); addr = 6'h05; #1;
    check("R2 relocked block", {7'd0, access_ok}, 8'h00);
    // R1 second reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd(6'h1B, v);
    check("R1 reset value", v, 8'h80);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule